// File: doc/BRIEF.md
# Burst-of-Two Split-Port SRAM Model

This block is a synthesizable, cycle-level model of a quad-data-rate style memory. It has one port that only reads and one port that only writes. Every access moves one 36-bit line as two 18-bit words, and the lower-order word always goes first. The model runs on a single beat clock at twice the rate of the memory's K clock. Each beat is therefore either a K half or a K# half.

The block owns the phase and shows it on `beat_k`. When `beat_k` is high, the next rising beat edge is a K edge. A controller drives the shared address bus with the read address at K edges and with the write address at K# edges. It also drives the two active-low port selects, the write word and the two active-low lane enables for each word. Read words come back on a registered bus with a valid flag, which stands in for a tri-state output. Byte lanes of a write whose enable is high leave their stored contents unchanged.

A write that started on the previous K edge has not yet reached the array when a new read begins. Its data is merged lane by lane into the read result, so a read always returns the latest committed contents.

Top module: `qdr_burst2_sram`

## Requirements
- R1: While reset is held and directly after it is released, `rvalid` is 0, `rdata` is 0 and `beat_k` is 1, so the first beat edge after reset is a K edge. `beat_k` then alternates every beat.
- R2: `rsel_n` and `wsel_n` are sampled only at K edges. Their values at K# edges have no effect.
- R3: A K edge with both selects high is a no-operation. The write data and lane enables presented in that cycle do not change the array, and no read burst is produced.
- R4: A line is 36 bits wide. Word 0 is line bits 17:0 and word 1 is line bits 35:18. A read returns word 0 first and then word 1.
- R5: For a read accepted at K edge e, word 0 is on `rdata` with `rvalid` high after beat edge e+3, which is the K# edge of the next cycle. Word 1 follows after beat edge e+4, which is a K edge.
- R6: For a write accepted at K edge e, word 0 is captured at edge e. The write address and word 1 are captured at edge e+1, the K# edge. The line is committed at the next K edge.
- R7: `be_n` is sampled with each word and is active low. Bit 0 guards word bits 8:0 and bit 1 guards word bits 17:9. A lane whose enable is high keeps its stored value.
- R8: Reads accepted at consecutive K edges produce an unbroken stream of words. When no read follows, `rvalid` falls after word 1, and `rdata` is 0 whenever `rvalid` is 0.
- R9: A read to the same location as a write that started on the previous K edge returns that write's data in the lanes it enabled. The other lanes return the older contents.
- R10: When a read and a write start at the same K edge to the same location, the read returns the contents as they were before that write.
- R11: The location index is the address modulo DEPTH, which is a power of two. Addresses beyond the depth wrap around.
- R12: Reads and writes to different locations may start at the same K edge, and neither disturbs the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock, two beats per K cycle |
| rst | input | 1 | Synchronous active-high reset |
| beat_k | output | 1 | High when the next rising beat edge is a K edge |
| addr | input | ADDR_W | Read address at K edges, write address at K# edges |
| rsel_n | input | 1 | Active-low read select, sampled at K edges |
| wsel_n | input | 1 | Active-low write select, sampled at K edges |
| wdata | input | WORD_W | Write word: word 0 at K, word 1 at K# |
| be_n | input | LANES | Active-low lane enables for the word being presented |
| rdata | output | WORD_W | Read word, zero when idle |
| rvalid | output | 1 | High while `rdata` carries a read word |

## Verification
Two functions can meet at the same K edge. One is a new read, which looks up the array. The other is the array commit of a write that started one cycle earlier; when both hit the same location, forwarding must merge the pending lanes. A read and a write can also start together at one K edge on the same location. In that case the read has to see the older contents, because the write address does not arrive until the K# edge.

The bench provokes both cases with masked writes to chosen addresses, followed either one cycle later or at the same edge by reads of the same address. It also runs a long random mix on a small address set so that such collisions happen often. Every beat of `rdata` and `rvalid` is compared against a behavioural line memory. That memory applies each write when its address arrives and serves each read when its K edge occurs.

// File: rtl/qdr_burst2_pkg.sv
package qdr_burst2_pkg;

  // Which half of the K cycle the next beat edge belongs to.
  typedef enum logic {
    PH_KBAR = 1'b0,
    PH_K    = 1'b1
  } beat_phase_e;

  // Words per line; the whole model assumes a burst of two.
  localparam int WORDS_PER_LINE = 2;

endpackage

// File: rtl/qdr_wr_capture.sv
module qdr_wr_capture #(
  parameter int ADDR_W = 20,
  parameter int IDX_W  = 8,
  parameter int WORD_W = 18,
  parameter int LANES  = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  k_edge,
  input  logic                  wsel_n,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [WORD_W-1:0]     wdata,
  input  logic [LANES-1:0]      be_n,
  output logic                  commit_en,
  output logic [IDX_W-1:0]      commit_idx,
  output logic [2*WORD_W-1:0]   commit_line,
  output logic [2*LANES-1:0]    commit_lanes
);

  localparam int LINE_W     = qdr_burst2_pkg::WORDS_PER_LINE * WORD_W;
  localparam int LINE_LANES = qdr_burst2_pkg::WORDS_PER_LINE * LANES;

  // Stage A: first word, captured at the K edge that starts the write.
  logic              a_v;
  logic [WORD_W-1:0] a_word;
  logic [LANES-1:0]  a_lanes;

  // Stage B: full line and index, captured at the following K# edge.
  logic                  b_v;
  logic [IDX_W-1:0]      b_idx;
  logic [LINE_W-1:0]     b_line;
  logic [LINE_LANES-1:0] b_lanes;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_v <= 1'b0;
      b_v <= 1'b0;
    end else if (k_edge) begin
      a_v     <= ~wsel_n;
      a_word  <= wdata;
      a_lanes <= ~be_n;
      b_v     <= 1'b0;          // committed at this K edge
    end else begin
      b_v     <= a_v;
      b_idx   <= addr[IDX_W-1:0];
      b_line  <= {wdata, a_word};
      b_lanes <= {~be_n, a_lanes};
    end
  end

  assign commit_en    = b_v & k_edge;
  assign commit_idx   = b_idx;
  assign commit_line  = b_line;
  assign commit_lanes = b_lanes;

  // R6: a write accepted at a K edge holds a complete line two beats later.
  p_line_ready_r6: assert property (@(posedge clk) disable iff (rst)
    (k_edge && !wsel_n) |-> ##2 b_v);

endmodule

// File: rtl/qdr_array.sv
module qdr_array #(
  parameter int DEPTH  = 256,
  parameter int IDX_W  = 8,
  parameter int WORD_W = 18,
  parameter int LANES  = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  k_edge,
  input  logic [IDX_W-1:0]      rd_idx,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [2*WORD_W-1:0]   wr_line,
  input  logic [2*LANES-1:0]    wr_lanes,
  output logic [2*WORD_W-1:0]   line_q,
  output logic [2*LANES-1:0]    fwd_lanes,
  output logic [2*WORD_W-1:0]   fwd_line
);

  localparam int LINE_W     = 2 * WORD_W;
  localparam int LINE_LANES = 2 * LANES;
  localparam int LANE_W     = WORD_W / LANES;

  logic [LINE_W-1:0] mem [DEPTH];

  // Lane-enabled write, read-before-write on the same edge (block RAM style).
  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int l = 0; l < LINE_LANES; l++) begin
        if (wr_lanes[l]) mem[wr_idx][l*LANE_W +: LANE_W] <= wr_line[l*LANE_W +: LANE_W];
      end
    end
    if (k_edge) begin
      line_q    <= mem[rd_idx];
      fwd_lanes <= (wr_en && (wr_idx == rd_idx)) ? wr_lanes : '0;
      fwd_line  <= wr_line;
    end
  end

  // R6: commits happen only on K edges, so never in two consecutive beats.
  p_commit_spacing_r6: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

endmodule

// File: rtl/qdr_rd_pipe.sv
module qdr_rd_pipe #(
  parameter int WORD_W = 18,
  parameter int LANES  = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  k_edge,
  input  logic                  rsel_n,
  input  logic [2*WORD_W-1:0]   line_q,
  input  logic [2*LANES-1:0]    fwd_lanes,
  input  logic [2*WORD_W-1:0]   fwd_line,
  output logic [WORD_W-1:0]     rdata,
  output logic                  rvalid
);

  localparam int LINE_W     = 2 * WORD_W;
  localparam int LINE_LANES = 2 * LANES;
  localparam int LANE_W     = WORD_W / LANES;

  logic [LINE_W-1:0] merged;

  for (genvar g = 0; g < LINE_LANES; g++) begin : g_lane
    assign merged[g*LANE_W +: LANE_W] = fwd_lanes[g] ? fwd_line[g*LANE_W +: LANE_W]
                                                     : line_q[g*LANE_W +: LANE_W];
  end

  logic              s_v;        // read accepted at last K edge
  logic              m_v;        // merged line ready
  logic [LINE_W-1:0] m_line;
  logic              hi_v;       // upper word waiting for the K edge
  logic [WORD_W-1:0] hi_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_v    <= 1'b0;
      m_v    <= 1'b0;
      hi_v   <= 1'b0;
      rvalid <= 1'b0;
      rdata  <= '0;
    end else if (k_edge) begin
      s_v    <= ~rsel_n;
      rvalid <= hi_v;
      rdata  <= hi_v ? hi_word : '0;
    end else begin
      m_v     <= s_v;
      m_line  <= merged;
      hi_v    <= m_v;
      hi_word <= m_line[LINE_W-1:WORD_W];
      rvalid  <= m_v;
      rdata   <= m_v ? m_line[WORD_W-1:0] : '0;
    end
  end

  // R8: an idle bus carries zeros.
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !rvalid |-> (rdata == '0));
  // R8: a burst that starts always delivers its second word.
  p_burst_two_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(rvalid) |=> rvalid);
  // R5: a burst begins on a K# edge, so the next edge is a K edge.
  p_lo_on_kbar_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(rvalid) |-> k_edge);

endmodule

// File: rtl/qdr_burst2_sram.sv
module qdr_burst2_sram #(
  parameter int ADDR_W = 20,
  parameter int DEPTH  = 256,
  parameter int WORD_W = 18,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  output logic              beat_k,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rsel_n,
  input  logic              wsel_n,
  input  logic [WORD_W-1:0] wdata,
  input  logic [LANES-1:0]  be_n,
  output logic [WORD_W-1:0] rdata,
  output logic              rvalid
);
  import qdr_burst2_pkg::*;

  localparam int IDX_W      = $clog2(DEPTH);
  localparam int LINE_W     = WORDS_PER_LINE * WORD_W;
  localparam int LINE_LANES = WORDS_PER_LINE * LANES;

  beat_phase_e ph;
  logic        k_edge;

  always_ff @(posedge clk) begin
    if (rst) ph <= PH_K;
    else     ph <= (ph == PH_K) ? PH_KBAR : PH_K;
  end

  assign k_edge = (ph == PH_K);
  assign beat_k = k_edge;

  logic                  c_en;
  logic [IDX_W-1:0]      c_idx;
  logic [LINE_W-1:0]     c_line;
  logic [LINE_LANES-1:0] c_lanes;
  logic [LINE_W-1:0]     a_line_q;
  logic [LINE_LANES-1:0] a_fwd_lanes;
  logic [LINE_W-1:0]     a_fwd_line;

  qdr_wr_capture #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .WORD_W(WORD_W), .LANES(LANES)) u_wr (
    .clk(clk), .rst(rst), .k_edge(k_edge), .wsel_n(wsel_n), .addr(addr),
    .wdata(wdata), .be_n(be_n), .commit_en(c_en), .commit_idx(c_idx),
    .commit_line(c_line), .commit_lanes(c_lanes)
  );

  qdr_array #(.DEPTH(DEPTH), .IDX_W(IDX_W), .WORD_W(WORD_W), .LANES(LANES)) u_arr (
    .clk(clk), .rst(rst), .k_edge(k_edge), .rd_idx(addr[IDX_W-1:0]),
    .wr_en(c_en), .wr_idx(c_idx), .wr_line(c_line), .wr_lanes(c_lanes),
    .line_q(a_line_q), .fwd_lanes(a_fwd_lanes), .fwd_line(a_fwd_line)
  );

  qdr_rd_pipe #(.WORD_W(WORD_W), .LANES(LANES)) u_rd (
    .clk(clk), .rst(rst), .k_edge(k_edge), .rsel_n(rsel_n),
    .line_q(a_line_q), .fwd_lanes(a_fwd_lanes), .fwd_line(a_fwd_line),
    .rdata(rdata), .rvalid(rvalid)
  );

  // R1: the beat phase alternates on every edge out of reset.
  p_phase_alt_r1: assert property (@(posedge clk) disable iff (rst)
    beat_k |=> !beat_k);

endmodule

// File: tb/qdr_burst2_sram_bench.sv
`timescale 1ns/1ps
module qdr_burst2_sram_bench;
  localparam int ADDR_W = 20;
  localparam int DEPTH  = 256;
  localparam int WORD_W = 18;
  localparam int LANES  = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              beat_k;
  logic [ADDR_W-1:0] addr = '0;
  logic              rsel_n = 1'b1;
  logic              wsel_n = 1'b1;
  logic [WORD_W-1:0] wdata = '0;
  logic [LANES-1:0]  be_n = '1;
  logic [WORD_W-1:0] rdata;
  logic              rvalid;

  always #2.5 clk = ~clk;

  qdr_burst2_sram #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .WORD_W(WORD_W), .LANES(LANES)) u_qdr_burst2_sram (
    .clk(clk), .rst(rst), .beat_k(beat_k), .addr(addr), .rsel_n(rsel_n),
    .wsel_n(wsel_n), .wdata(wdata), .be_n(be_n), .rdata(rdata), .rvalid(rvalid)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_req = "R1";

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference: line memory and per-beat expectations.
  logic [35:0] ref_mem [DEPTH];
  bit          exp_v [16];
  logic [17:0] exp_d [16];
  int          edge_n = 0;
  bit          m_wpend = 0;
  logic [17:0] m_d0;
  logic [1:0]  m_en0;

  always @(posedge clk) begin
    if (rst) begin
      edge_n = 0;
      m_wpend = 0;
      for (int i = 0; i < 16; i++) exp_v[i] = 0;
    end else begin
      if (edge_n % 2 == 0) begin
        if (!rsel_n) begin
          exp_v[(edge_n + 3) % 16] = 1;
          exp_d[(edge_n + 3) % 16] = ref_mem[addr % DEPTH][17:0];
          exp_v[(edge_n + 4) % 16] = 1;
          exp_d[(edge_n + 4) % 16] = ref_mem[addr % DEPTH][35:18];
        end
        m_wpend = !wsel_n;
        m_d0 = wdata;
        m_en0 = ~be_n;
      end else if (m_wpend) begin
        logic [35:0] ln;
        logic [3:0]  en;
        ln = {wdata, m_d0};
        en = {~be_n, m_en0};
        for (int l = 0; l < 4; l++)
          if (en[l]) ref_mem[addr % DEPTH][l*9 +: 9] = ln[l*9 +: 9];
        m_wpend = 0;
      end
      edge_n++;
    end
  end

  always @(negedge clk) begin
    if (!rst && edge_n > 0) begin
      int i;
      i = (edge_n - 1) % 16;
      chk(rvalid === exp_v[i], cur_req, "rvalid", longint'(rvalid), longint'(exp_v[i]));
      if (exp_v[i])
        chk(rdata === exp_d[i], cur_req, "rdata", longint'(rdata), longint'(exp_d[i]));
      else
        chk(rdata === '0, cur_req, "idle rdata", longint'(rdata), 0);
      exp_v[i] = 0;
    end
  end

  // One K cycle: K-edge inputs, then K#-edge inputs with junk selects (R2).
  task automatic kcyc(input bit rd, input logic [ADDR_W-1:0] ra, input bit wr,
                      input logic [ADDR_W-1:0] wa, input logic [35:0] wd,
                      input logic [3:0] wen_n);
    do @(negedge clk); while (beat_k !== 1'b1);
    rsel_n = !rd;
    wsel_n = !wr;
    addr   = ra;
    wdata  = wd[17:0];
    be_n   = wen_n[1:0];
    @(negedge clk);
    rsel_n = 1'($urandom);
    wsel_n = 1'($urandom);
    addr   = wa;
    wdata  = wd[35:18];
    be_n   = wen_n[3:2];
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) kcyc(0, 20'($urandom), 0, 20'($urandom), {$urandom, 4'($urandom)}, 4'($urandom));
  endtask

  function automatic logic [35:0] pat(input int a);
    return {18'(a * 7 + 3), 18'(a ^ 18'h2AAAA)};
  endfunction

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL R5 watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(rvalid === 1'b0, "R1", "rvalid in reset", longint'(rvalid), 0);
    chk(rdata === '0, "R1", "rdata in reset", longint'(rdata), 0);
    rst = 1'b0;
    chk(beat_k === 1'b1, "R1", "beat_k after reset", longint'(beat_k), 1);
    @(negedge clk);
    chk(beat_k === 1'b0, "R1", "beat_k alternates", longint'(beat_k), 0);

    // R6 / R4: fill every location
    cur_req = "R6";
    for (int a = 0; a < DEPTH; a++) kcyc(0, 0, 1, 20'(a), pat(a), 4'b0000);
    idle(2);

    // R5 / R4: isolated read
    cur_req = "R5";
    kcyc(1, 20'd5, 0, 0, 0, 4'hF);
    idle(3);
    // R8: back-to-back reads then idle
    cur_req = "R8";
    for (int a = 1; a < 5; a++) kcyc(1, 20'(a), 0, 0, 0, 4'hF);
    idle(3);

    // R7: lane masks per word
    cur_req = "R7";
    kcyc(0, 0, 1, 20'd10, 36'hF_FFFF_FFFF, 4'b0101);
    kcyc(0, 0, 1, 20'd11, 36'h0_0000_0000, 4'b1010);
    idle(1);
    kcyc(1, 20'd10, 0, 0, 0, 4'hF);
    kcyc(1, 20'd11, 0, 0, 0, 4'hF);
    idle(3);

    // R3 / R2: no-operation cycles with garbage, then read back
    cur_req = "R3";
    for (int k = 0; k < 4; k++) begin
      do @(negedge clk); while (beat_k !== 1'b1);
      rsel_n = 1; wsel_n = 1; addr = 20'd12; wdata = 18'h3FFFF; be_n = 2'b00;
      @(negedge clk);
      rsel_n = 0; wsel_n = 0; addr = 20'd12; wdata = 18'h15555; be_n = 2'b00;
    end
    cur_req = "R2";
    kcyc(1, 20'd12, 0, 0, 0, 4'hF);
    idle(3);

    // R9: forwarding from write one cycle earlier, masked
    cur_req = "R9";
    kcyc(0, 0, 1, 20'd20, 36'h1_2345_6789, 4'b0110);
    kcyc(1, 20'd20, 0, 0, 0, 4'hF);
    idle(1);
    kcyc(0, 0, 1, 20'd21, 36'hA_BCDE_F012, 4'b0000);
    kcyc(1, 20'd21, 1, 20'd22, 36'h5_5555_5555, 4'b0000);
    kcyc(1, 20'd22, 0, 0, 0, 4'hF);
    idle(3);

    // R10: read and write same location same edge
    cur_req = "R10";
    kcyc(1, 20'd30, 1, 20'd30, 36'h9_8765_4321, 4'b0000);
    kcyc(1, 20'd30, 0, 0, 0, 4'hF);
    idle(3);

    // R12: independent ports, different locations
    cur_req = "R12";
    kcyc(1, 20'd40, 1, 20'd41, 36'h0_F0F0_F0F0, 4'b0000);
    kcyc(1, 20'd41, 1, 20'd40, 36'h3_3333_3333, 4'b0011);
    kcyc(1, 20'd40, 0, 0, 0, 4'hF);
    idle(3);

    // R11: address wrap
    cur_req = "R11";
    kcyc(0, 0, 1, 20'(DEPTH + 7), 36'h7_7777_7777, 4'b0000);
    idle(1);
    kcyc(1, 20'd7, 0, 0, 0, 4'hF);
    kcyc(1, 20'(2 * DEPTH + 7), 0, 0, 0, 4'hF);
    idle(3);

    // R12 / R9 / R10: random mix on a small location set
    cur_req = "R12";
    for (int k = 0; k < 600; k++) begin
      logic [ADDR_W-1:0] ra, wa;
      ra = {12'($urandom), 4'b0000, 4'($urandom)};
      wa = {12'($urandom), 4'b0000, 4'($urandom)};
      kcyc(1'($urandom), ra, 1'($urandom), wa, {$urandom, 4'($urandom)}, 4'($urandom));
    end
    idle(4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule